// File: doc/BRIEF.md
# Dataflow Issue Queue

This block sits between the register renamer and the execution ports of an out-of-order core. Each renamed micro-operation is written into one of twenty slots together with its two operands. The renamer may hand over an operand already present: an immediate, a committed register value, or the result held in a finished reorder slot. In that case the value is stored with a ready flag. Otherwise the slot keeps the reorder tag of the producer and watches the single result broadcast bus until that tag appears.

A slot whose operands are both present may leave for the execution port that matches its kind, as long as that port is not busy. Three ports exist: integer, floating point, and address generation for memory operations. When several slots compete for one port, the one allocated earliest wins. A younger uop with its data in hand therefore overtakes an older one that is still waiting. A flush, given as a reorder tag, discards every slot holding a younger uop.

Top module: `rs_station`

## Requirements
- R1: The queue holds 20 slots. `alloc_stall` is high whenever fewer than 3 slots are free, and an allocation offered while it is high is dropped. At most 18 slots are ever occupied.
- R2: An operand offered with its ready flag set (immediate, committed register or finished reorder value) is stored as given. A uop with both operands ready is presented on its port in the cycle after its allocation.
- R3: A waiting operand takes `wb_data` when `wb_valid` is high and `wb_tag` equals its tag. The uop can then be presented in the cycle after that broadcast, and not before.
- R4: A broadcast in the same cycle as the allocation of a uop waiting on that tag is captured.
- R5: Kind code 0 selects issue port 0 (integer), code 1 port 1 (floating point), and code 2 port 2 (address generation, used for memory uops).
- R6: No uop is presented on a port while its `port_busy` bit is high. A ready uop waits until the bit falls.
- R7: Among the ready uops of one port, the earliest allocated is presented first. Issue order does not follow program order when an older uop is still waiting.
- R8: A presented uop leaves the queue at the next clock edge and is presented exactly once.
- R9: With `flush_valid` high, every slot whose reorder tag t satisfies (t - `flush_rob`) mod 128 in 1..63 is discarded and never presented, while the other slots stay. An allocation offered in that cycle is dropped.
- R10: After reset no slot is occupied, nothing is presented and `alloc_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Offer a new uop |
| alloc_kind | input | 2 | Port kind: 0 integer, 1 float, 2 address |
| alloc_rob | input | 7 | Reorder tag of the uop |
| alloc_op | input | 8 | Operation code, passed through |
| alloc_a_rdy | input | 1 | Operand A value present |
| alloc_a_tag | input | 7 | Producer tag of operand A |
| alloc_a_val | input | 32 | Operand A value |
| alloc_b_rdy | input | 1 | Operand B value present |
| alloc_b_tag | input | 7 | Producer tag of operand B |
| alloc_b_val | input | 32 | Operand B value |
| alloc_stall | output | 1 | Fewer than 3 slots free |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 7 | Tag of broadcast result |
| wb_data | input | 32 | Broadcast result value |
| port_busy | input | 3 | Per-port busy |
| flush_valid | input | 1 | Discard younger uops |
| flush_rob | input | 7 | Reorder tag of the flush point |
| iss_valid | output | 3 | Per-port issue valid |
| iss_rob | output | 3x7 | Reorder tag per port |
| iss_op | output | 3x8 | Operation code per port |
| iss_a | output | 3x32 | Operand A per port |
| iss_b | output | 3x32 | Operand B per port |

## Verification
Issue outputs are driven directly from the slot registers, qualified by the busy and flush inputs of the same cycle. A uop allocated at one edge is therefore due in the cycle after that edge, and a wakeup broadcast at one edge releases its uop in the cycle that follows. The bench changes inputs one nanosecond after the falling edge and samples three nanoseconds after it, so each sample sees the registered state together with the current inputs. Expected issues are queued per port in the order the age rule dictates, and every presented uop is matched against the head of its queue. Direct checks also confirm the cycles in which nothing may appear.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int NUM_PORTS = 3;
    localparam int KIND_W    = 2;
    localparam logic [KIND_W-1:0] KIND_INT = 2'd0;
    localparam logic [KIND_W-1:0] KIND_FP  = 2'd1;
    localparam logic [KIND_W-1:0] KIND_AGU = 2'd2;
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int DEPTH    = 20,
    parameter int MIN_FREE = 3,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] slot_valid,
    output logic             found,
    output logic [IDX_W-1:0] free_idx,
    output logic [CNT_W-1:0] free_cnt,
    output logic             stall
);
    always_comb begin
        found    = 1'b0;
        free_idx = '0;
        free_cnt = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                found    = 1'b1;
                free_idx = IDX_W'(i);
            end
            free_cnt = free_cnt + CNT_W'(!slot_valid[i]);
        end
        stall = (free_cnt < CNT_W'(MIN_FREE));
    end
endmodule

// File: rtl/rs_age_arb.sv
module rs_age_arb #(
    parameter int DEPTH = 20,
    parameter int PORTS = 3,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [IDX_W-1:0]            alloc_idx,
    input  logic [PORTS-1:0][DEPTH-1:0] req,
    output logic [PORTS-1:0][DEPTH-1:0] gnt
);
    // older[j][i] set: slot j was allocated before slot i
    typedef struct packed {
        logic [DEPTH-1:0][DEPTH-1:0] older;
    } age_t;

    age_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (alloc_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                age_d.older[alloc_idx][j] = 1'b0;
                age_d.older[j][alloc_idx] = (IDX_W'(j) != alloc_idx);
            end
        end
        for (int p = 0; p < PORTS; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                logic blocked;
                blocked = 1'b0;
                for (int j = 0; j < DEPTH; j++) begin
                    blocked = blocked | (req[p][j] & age_q.older[j][i]);
                end
                gnt[p][i] = req[p][i] & ~blocked;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[p]));
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DEPTH    = 20,
    parameter int MIN_FREE = 3,
    parameter int ROB_W    = 7,
    parameter int DATA_W   = 32,
    parameter int OP_W     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_valid,
    input  logic [KIND_W-1:0]                alloc_kind,
    input  logic [ROB_W-1:0]                 alloc_rob,
    input  logic [OP_W-1:0]                  alloc_op,
    input  logic                             alloc_a_rdy,
    input  logic [ROB_W-1:0]                 alloc_a_tag,
    input  logic [DATA_W-1:0]                alloc_a_val,
    input  logic                             alloc_b_rdy,
    input  logic [ROB_W-1:0]                 alloc_b_tag,
    input  logic [DATA_W-1:0]                alloc_b_val,
    output logic                             alloc_stall,
    input  logic                             wb_valid,
    input  logic [ROB_W-1:0]                 wb_tag,
    input  logic [DATA_W-1:0]                wb_data,
    input  logic [NUM_PORTS-1:0]             port_busy,
    input  logic                             flush_valid,
    input  logic [ROB_W-1:0]                 flush_rob,
    output logic [NUM_PORTS-1:0]             iss_valid,
    output logic [NUM_PORTS-1:0][ROB_W-1:0]  iss_rob,
    output logic [NUM_PORTS-1:0][OP_W-1:0]   iss_op,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] iss_a,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] iss_b
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              rdy;
        logic [ROB_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic              valid;
        logic [KIND_W-1:0] kind;
        logic [ROB_W-1:0]  rob;
        logic [OP_W-1:0]   op;
        opnd_t             a;
        opnd_t             b;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH-1:0]                slot_valid;
    logic                            pick_found;
    logic [IDX_W-1:0]                pick_idx;
    logic [CNT_W-1:0]                free_cnt;
    logic                            alloc_fire;
    logic [NUM_PORTS-1:0][DEPTH-1:0] req;
    logic [NUM_PORTS-1:0][DEPTH-1:0] gnt;

    function automatic opnd_t snoop(input opnd_t o, input logic hit_v,
                                    input logic [ROB_W-1:0] hit_tag,
                                    input logic [DATA_W-1:0] hit_val);
        opnd_t r;
        r = o;
        if (!o.rdy && hit_v && (o.tag == hit_tag)) begin
            r.rdy = 1'b1;
            r.val = hit_val;
        end
        return r;
    endfunction

    function automatic logic is_younger(input logic [ROB_W-1:0] t,
                                        input logic [ROB_W-1:0] point);
        logic [ROB_W-1:0] diff;
        diff = t - point;
        return (diff != '0) && !diff[ROB_W-1];
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) slot_valid[i] = st_q.slot[i].valid;
    end

    rs_free_pick #(
        .DEPTH(DEPTH), .MIN_FREE(MIN_FREE), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) i_pick (
        .slot_valid(slot_valid),
        .found     (pick_found),
        .free_idx  (pick_idx),
        .free_cnt  (free_cnt),
        .stall     (alloc_stall)
    );

    assign alloc_fire = alloc_valid && !alloc_stall && !flush_valid && pick_found;

    // requests: operands present, kind matches port, port free, not being flushed
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                req[p][i] = st_q.slot[i].valid && st_q.slot[i].a.rdy && st_q.slot[i].b.rdy
                         && (st_q.slot[i].kind == KIND_W'(p)) && !port_busy[p]
                         && !(flush_valid && is_younger(st_q.slot[i].rob, flush_rob));
            end
        end
    end

    rs_age_arb #(
        .DEPTH(DEPTH), .PORTS(NUM_PORTS), .IDX_W(IDX_W)
    ) i_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc_fire),
        .alloc_idx(pick_idx),
        .req      (req),
        .gnt      (gnt)
    );

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            iss_valid[p] = |gnt[p];
            iss_rob[p]   = '0;
            iss_op[p]    = '0;
            iss_a[p]     = '0;
            iss_b[p]     = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (gnt[p][i]) begin
                    iss_rob[p] = iss_rob[p] | st_q.slot[i].rob;
                    iss_op[p]  = iss_op[p]  | st_q.slot[i].op;
                    iss_a[p]   = iss_a[p]   | st_q.slot[i].a.val;
                    iss_b[p]   = iss_b[p]   | st_q.slot[i].b.val;
                end
            end
        end
    end

    always_comb begin
        slot_t nw;
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            logic gone;
            gone = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) gone = gone | gnt[p][i];
            if (flush_valid && is_younger(st_q.slot[i].rob, flush_rob)) gone = 1'b1;
            if (st_q.slot[i].valid) begin
                st_d.slot[i].a = snoop(st_q.slot[i].a, wb_valid, wb_tag, wb_data);
                st_d.slot[i].b = snoop(st_q.slot[i].b, wb_valid, wb_tag, wb_data);
            end
            if (gone) st_d.slot[i].valid = 1'b0;
        end
        nw.valid = 1'b1;
        nw.kind  = alloc_kind;
        nw.rob   = alloc_rob;
        nw.op    = alloc_op;
        nw.a     = snoop('{rdy: alloc_a_rdy, tag: alloc_a_tag, val: alloc_a_val},
                         wb_valid, wb_tag, wb_data);
        nw.b     = snoop('{rdy: alloc_b_rdy, tag: alloc_b_tag, val: alloc_b_val},
                         wb_valid, wb_tag, wb_data);
        if (alloc_fire) st_d.slot[pick_idx] = nw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r1_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt >= CNT_W'(MIN_FREE - 1));

    a_r1_stall_drops: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |=> free_cnt >= $past(free_cnt));

    a_r9_flush_drops_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> free_cnt >= $past(free_cnt));

    a_r8_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (|iss_valid) |=> free_cnt >= $past(free_cnt));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy[p] |-> !iss_valid[p]);
    end
endmodule

// File: tb/test_rs_station.sv
`timescale 1ns/1ps
module test_rs_station;
    typedef struct packed {
        logic [6:0]  rob;
        logic [31:0] a;
        logic [31:0] b;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0;
    logic [1:0] alloc_kind = 0;
    logic [6:0] alloc_rob = 0;
    logic [7:0] alloc_op = 0;
    logic alloc_a_rdy = 0, alloc_b_rdy = 0;
    logic [6:0] alloc_a_tag = 0, alloc_b_tag = 0;
    logic [31:0] alloc_a_val = 0, alloc_b_val = 0;
    logic alloc_stall;
    logic wb_valid = 0;
    logic [6:0] wb_tag = 0;
    logic [31:0] wb_data = 0;
    logic [2:0] port_busy = 0;
    logic flush_valid = 0;
    logic [6:0] flush_rob = 0;
    logic [2:0] iss_valid;
    logic [2:0][6:0] iss_rob;
    logic [2:0][7:0] iss_op;
    logic [2:0][31:0] iss_a;
    logic [2:0][31:0] iss_b;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t q0[$], q1[$], q2[$];

    always #4 clk = ~clk;

    rs_station i_rs_station (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_rob(alloc_rob),
        .alloc_op(alloc_op), .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag),
        .alloc_a_val(alloc_a_val), .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag),
        .alloc_b_val(alloc_b_val), .alloc_stall(alloc_stall),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .port_busy(port_busy), .flush_valid(flush_valid), .flush_rob(flush_rob),
        .iss_valid(iss_valid), .iss_rob(iss_rob), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // inputs change 1 ns after the falling edge
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input int port, input logic [6:0] rob,
                        input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        e = '{rob: rob, a: a, b: b};
        if (port == 0) q0.push_back(e);
        else if (port == 1) q1.push_back(e);
        else q2.push_back(e);
    endtask

    task automatic do_alloc(input logic [1:0] kind, input logic [6:0] rob,
                            input logic ar, input logic [6:0] at, input logic [31:0] av,
                            input logic br, input logic [6:0] bt, input logic [31:0] bv);
        alloc_valid = 1; alloc_kind = kind; alloc_rob = rob; alloc_op = {1'b0, rob};
        alloc_a_rdy = ar; alloc_a_tag = at; alloc_a_val = av;
        alloc_b_rdy = br; alloc_b_tag = bt; alloc_b_val = bv;
        tick();
        alloc_valid = 0;
    endtask

    // monitor: 3 ns after the falling edge, compare each issue with its queue head
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                for (int p = 0; p < 3; p++) begin
                    if (iss_valid[p]) begin
                        exp_t e;
                        int n;
                        n = (p == 0) ? q0.size() : (p == 1) ? q1.size() : q2.size();
                        if (n == 0) begin
                            chk(0, "R8", $sformatf("unexpected issue port%0d", p),
                                64'(iss_rob[p]), 64'h0);
                        end else begin
                            if (p == 0) e = q0.pop_front();
                            else if (p == 1) e = q1.pop_front();
                            else e = q2.pop_front();
                            chk(iss_rob[p] == e.rob, "R7", $sformatf("rob port%0d", p),
                                64'(iss_rob[p]), 64'(e.rob));
                            chk(iss_a[p] == e.a && iss_b[p] == e.b, "R2",
                                $sformatf("operands port%0d", p),
                                {iss_a[p], iss_b[p]}, {e.a, e.b});
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            chk(0, "R8", "watchdog expired", 64'h0, 64'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        #1;
        chk(iss_valid == 3'b000, "R10", "no issue after reset", 64'(iss_valid), 64'h0);
        chk(alloc_stall == 1'b0, "R10", "stall low after reset", 64'(alloc_stall), 64'h0);
        #1;

        // R2 / R5: ready operands, integer port, issued next cycle
        push(0, 7'd1, 32'd10, 32'd20);
        do_alloc(2'd0, 7'd1, 1, 0, 32'd10, 1, 0, 32'd20);
        #1;
        chk(iss_valid[0] == 1'b1, "R2", "issue the cycle after allocation", 64'(iss_valid), 64'h1);
        #1;
        tick();

        // R3: floating-point uop waits for tag 40
        do_alloc(2'd1, 7'd2, 0, 7'd40, 32'd0, 1, 0, 32'h33);
        tick();
        #1;
        chk(iss_valid[1] == 1'b0, "R3", "waiting uop not issued", 64'(iss_valid), 64'h0);
        #1;
        push(1, 7'd2, 32'h55, 32'h33);
        wb_valid = 1; wb_tag = 7'd40; wb_data = 32'h55;
        #1;
        chk(iss_valid[1] == 1'b0, "R3", "not issued in broadcast cycle", 64'(iss_valid), 64'h0);
        #1;
        tick();
        wb_valid = 0;
        #1;
        chk(iss_valid[1] == 1'b1, "R3", "issued after broadcast", 64'(iss_valid), 64'h2);
        #1;
        tick();

        // R4 / R5: memory uop on address port, broadcast during allocation
        push(2, 7'd3, 32'h77, 32'h9);
        wb_valid = 1; wb_tag = 7'd41; wb_data = 32'h77;
        do_alloc(2'd2, 7'd3, 0, 7'd41, 32'd0, 1, 0, 32'h9);
        wb_valid = 0;
        #1;
        chk(iss_valid == 3'b100, "R4", "same-cycle capture, address port", 64'(iss_valid), 64'h4);
        #1;
        tick();

        // R6: busy port holds a ready uop
        port_busy = 3'b001;
        do_alloc(2'd0, 7'd4, 1, 0, 32'd4, 1, 0, 32'd5);
        repeat (3) begin
            #1;
            chk(iss_valid[0] == 1'b0, "R6", "held while busy", 64'(iss_valid), 64'h0);
            #1;
            tick();
        end
        push(0, 7'd4, 32'd4, 32'd5);
        port_busy = 3'b000;
        #1;
        chk(iss_valid[0] == 1'b1, "R6", "released when port frees", 64'(iss_valid), 64'h1);
        #1;
        tick();

        // R7: oldest first among ready uops
        port_busy = 3'b001;
        do_alloc(2'd0, 7'd5, 1, 0, 32'd50, 1, 0, 32'd51);
        do_alloc(2'd0, 7'd6, 1, 0, 32'd60, 1, 0, 32'd61);
        do_alloc(2'd0, 7'd7, 1, 0, 32'd70, 1, 0, 32'd71);
        push(0, 7'd5, 32'd50, 32'd51);
        push(0, 7'd6, 32'd60, 32'd61);
        push(0, 7'd7, 32'd70, 32'd71);
        port_busy = 3'b000;
        repeat (4) tick();

        // R7: younger ready uop overtakes older waiting one
        push(0, 7'd9, 32'd90, 32'd91);
        push(0, 7'd8, 32'h88, 32'd81);
        do_alloc(2'd0, 7'd8, 0, 7'd42, 32'd0, 1, 0, 32'd81);
        do_alloc(2'd0, 7'd9, 1, 0, 32'd90, 1, 0, 32'd91);
        wb_valid = 1; wb_tag = 7'd42; wb_data = 32'h88;
        tick();
        wb_valid = 0;
        repeat (3) tick();

        // R1: capacity and stall
        port_busy = 3'b111;
        for (int k = 0; k < 18; k++) begin
            #1;
            chk(alloc_stall == 1'b0, "R1", $sformatf("stall low with %0d used", k),
                64'(alloc_stall), 64'h0);
            #1;
            do_alloc(2'd0, 7'(20 + k), 1, 0, 32'(k), 1, 0, 32'(k + 100));
            push(0, 7'(20 + k), 32'(k), 32'(k + 100));
        end
        #1;
        chk(alloc_stall == 1'b1, "R1", "stall high with 2 free", 64'(alloc_stall), 64'h1);
        #1;
        do_alloc(2'd0, 7'd90, 1, 0, 32'd0, 1, 0, 32'd0);
        port_busy = 3'b000;
        repeat (22) tick();
        #1;
        chk(alloc_stall == 1'b0, "R1", "stall low after drain", 64'(alloc_stall), 64'h0);
        chk(q0.size() == 0, "R1", "all 18 issued, dropped one absent", 64'(q0.size()), 64'h0);
        #1;

        // R9: flush drops younger slots and same-cycle allocation
        port_busy = 3'b001;
        do_alloc(2'd0, 7'd50, 1, 0, 32'd1, 1, 0, 32'd2);
        do_alloc(2'd0, 7'd51, 1, 0, 32'd3, 1, 0, 32'd4);
        do_alloc(2'd0, 7'd52, 1, 0, 32'd5, 1, 0, 32'd6);
        do_alloc(2'd0, 7'd53, 1, 0, 32'd7, 1, 0, 32'd8);
        flush_valid = 1; flush_rob = 7'd51;
        do_alloc(2'd0, 7'd60, 1, 0, 32'd9, 1, 0, 32'd9);
        flush_valid = 0;
        push(0, 7'd50, 32'd1, 32'd2);
        push(0, 7'd51, 32'd3, 32'd4);
        port_busy = 3'b000;
        repeat (5) tick();

        // R9: wrap-around of the tag space
        port_busy = 3'b001;
        do_alloc(2'd0, 7'd120, 1, 0, 32'd11, 1, 0, 32'd12);
        do_alloc(2'd0, 7'd126, 1, 0, 32'd13, 1, 0, 32'd14);
        do_alloc(2'd0, 7'd1, 1, 0, 32'd15, 1, 0, 32'd16);
        flush_valid = 1; flush_rob = 7'd126;
        tick();
        flush_valid = 0;
        push(0, 7'd120, 32'd11, 32'd12);
        push(0, 7'd126, 32'd13, 32'd14);
        port_busy = 3'b000;
        repeat (5) tick();

        #1;
        chk(q0.size() == 0, "R9", "port0 queue drained", 64'(q0.size()), 64'h0);
        chk(q1.size() == 0, "R8", "port1 queue drained", 64'(q1.size()), 64'h0);
        chk(q2.size() == 0, "R5", "port2 queue drained", 64'(q2.size()), 64'h0);
        chk(iss_valid == 3'b000, "R8", "nothing left to issue", 64'(iss_valid), 64'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule